// File: doc/BRIEF.md
# Directed-Mode Significand Rounder

This stage takes a normalised significand with three extra low-order bits (guard, round and sticky) and rounds it to the significand width. A 2-bit mode input picks the rounding direction. For the two directed modes the sign of the value decides whether the magnitude grows. The stage reports whether any discarded bit was nonzero. It also raises a carry-out when the increment overflows the width, so the exponent logic upstream can adjust.

The rounding logic is combinational. A parameter places an output register behind it, with a clock enable. The stage handles no exponents, no special values and no overflow to infinity. Those belong to the neighbouring stages.

Top module: `fp_round_stage`

## Requirements
- R1: `mode_i` encodes the rounding direction. 0 is nearest-even, 1 is toward zero, 2 is toward plus infinity and 3 is toward minus infinity. In `grs_i`, bit 2 is guard, bit 1 is round and bit 0 is sticky.
- R2: In mode 0 the significand is incremented when guard is 1 and at least one of round, sticky or the significand LSB is 1. An exact tie therefore resolves to an even LSB.
- R3: In mode 1 the significand is never incremented; the output is the truncated input.
- R4: In mode 2 the significand is incremented exactly when `sign_i` is 0 and `grs_i` is nonzero.
- R5: In mode 3 the significand is incremented exactly when `sign_i` is 1 and `grs_i` is nonzero.
- R6: `inexact_o` is 1 exactly when `grs_i` is nonzero, in every mode.
- R7: When `grs_i` is zero the significand passes through unchanged with `carry_o` 0, in every mode and for either sign.
- R8: When an all-ones significand is incremented, `carry_o` is 1 and `sig_o` has only its MSB set.
- R9: With `OUT_REG`=1 the outputs reflect the inputs present at a rising clock edge where `en_i` is 1. They hold their value across edges where `en_i` is 0.
- R10: With `OUT_REG`=1, all outputs are 0 while `rst_ni` is low. They stay 0 until the first enabled edge after the synchronised release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Clock enable for the output register |
| sign_i | input | 1 | Sign of the value, 1 for negative |
| sig_i | input | SIG_W | Normalised significand before rounding |
| grs_i | input | 3 | Guard, round and sticky bits |
| mode_i | input | 2 | Rounding direction |
| sig_o | output | SIG_W | Rounded significand |
| carry_o | output | 1 | Increment overflowed the width |
| inexact_o | output | 1 | A discarded bit was nonzero |

## Verification
Directed patterns are applied in every mode with both signs:
- Exact halfway cases on odd and even LSBs separate tie-to-even from tie-away behaviour.
- Values just below and just above the halfway point test whether the guard bit alone is given the right weight against round and sticky.
- An all-ones significand exposes the carry and leading-one path.
- Exact inputs confirm that no mode nudges a representable value.

Stretches with the enable held low show the register holding its value. A long run of random sign, significand, extra bits and mode then covers the remaining mix of cases against the behavioural model.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_TO_POS    = 2'd2,
    RND_TO_NEG    = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic guard;
    logic rnd;
    logic sticky;
  } xbits_t;
endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
(
  input  rnd_mode_e mode_i,
  input  logic      sign_i,
  input  logic      lsb_i,
  input  xbits_t    xb_i,
  output logic      inc_o,
  output logic      inexact_o
);
  logic lost;

  always_comb begin
    lost      = xb_i.guard | xb_i.rnd | xb_i.sticky;
    inexact_o = lost;
    unique case (mode_i)
      RND_NEAR_EVEN: inc_o = xb_i.guard & (xb_i.rnd | xb_i.sticky | lsb_i);
      RND_TO_ZERO:   inc_o = 1'b0;
      RND_TO_POS:    inc_o = lost & ~sign_i;
      RND_TO_NEG:    inc_o = lost & sign_i;
      default:       inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             inc_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             carry_o
);
  localparam int SUM_W = SIG_W + 1;
  localparam logic [SIG_W-1:0] LEAD_ONE = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum     = {1'b0, sig_i} + {{SIG_W{1'b0}}, inc_i};
    carry_o = sum[SUM_W-1];
    sig_o   = carry_o ? LEAD_ONE : sum[SIG_W-1:0];
  end
endmodule

// File: rtl/fpr_outreg.sv
module fpr_outreg #(
  parameter int  DW      = 8,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  generate
    if (OUT_REG) begin : g_reg
      logic [1:0]    rst_sync_q;
      logic          rst_int_n;
      logic [DW-1:0] q_reg;
      logic [DW-1:0] q_next;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= 2'b00;
        else         rst_sync_q <= {rst_sync_q[0], 1'b1};
      end
      assign rst_int_n = rst_sync_q[1];

      always_comb begin
        q_next = en_i ? d_i : q_reg;
      end

      always_ff @(posedge clk_i or negedge rst_int_n) begin
        if (!rst_int_n) q_reg <= '0;
        else            q_reg <= q_next;
      end

      assign q_o = q_reg;
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage
  import fpr_pkg::*;
#(
  parameter int SIG_W   = 24,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sign_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [2:0]       grs_i,
  input  logic [1:0]       mode_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             carry_o,
  output logic             inexact_o
);
  localparam int PACK_W = SIG_W + 2;

  rnd_mode_e        mode;
  xbits_t           xb;
  logic             inc;
  logic             inexact_c;
  logic [SIG_W-1:0] rnd_sig;
  logic             rnd_carry;
  logic [PACK_W-1:0] packed_d;
  logic [PACK_W-1:0] packed_q;

  assign mode = rnd_mode_e'(mode_i);
  assign xb   = xbits_t'(grs_i);

  fpr_decide u_decide (
    .mode_i    (mode),
    .sign_i    (sign_i),
    .lsb_i     (sig_i[0]),
    .xb_i      (xb),
    .inc_o     (inc),
    .inexact_o (inexact_c)
  );

  fpr_incr #(.SIG_W(SIG_W)) u_incr (
    .sig_i   (sig_i),
    .inc_i   (inc),
    .sig_o   (rnd_sig),
    .carry_o (rnd_carry)
  );

  assign packed_d = {rnd_sig, rnd_carry, inexact_c};

  fpr_outreg #(.DW(PACK_W), .OUT_REG(OUT_REG)) u_outreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (packed_d),
    .q_o    (packed_q)
  );

  assign sig_o     = packed_q[PACK_W-1:2];
  assign carry_o   = packed_q[1];
  assign inexact_o = packed_q[0];

  // R3
  rz_no_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == RND_TO_ZERO) |-> (rnd_sig == sig_i && !rnd_carry));

  // R4
  rp_neg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == RND_TO_POS && sign_i) |-> (rnd_sig == sig_i && !rnd_carry));

  // R5
  rm_pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == RND_TO_NEG && !sign_i) |-> (rnd_sig == sig_i && !rnd_carry));

  // R7
  exact_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grs_i == 3'b000) |-> (rnd_sig == sig_i && !rnd_carry && !inexact_c));

  // R8
  wrap_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_carry |-> ((&sig_i) && $countones(rnd_sig) == 1 && rnd_sig[SIG_W-1]));
endmodule

// File: tb/fp_round_stage_bench.sv
module fp_round_stage_bench;
  localparam int W = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         en;
  logic         sign;
  logic [W-1:0] sig;
  logic [2:0]   grs;
  logic [1:0]   mode;
  logic [W-1:0] sig_o;
  logic         carry_o;
  logic         inexact_o;

  fp_round_stage #(.SIG_W(W), .OUT_REG(1'b1)) u_fp_round_stage (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sign_i(sign), .sig_i(sig),
    .grs_i(grs), .mode_i(mode), .sig_o(sig_o), .carry_o(carry_o),
    .inexact_o(inexact_o)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  longint e_sig = 0;
  bit     e_c   = 1'b0;
  bit     e_x   = 1'b0;

  // Behavioural reference: rounds the integer value m by the extra bits g.
  task automatic ref_round(input bit s, input longint m, input int g, input int md,
                           output longint o, output bit c, output bit x);
    bit     up;
    longint t;
    x = (g != 0);
    case (md)
      0:       up = (g > 4) || (g == 4 && (m % 2) == 1);
      1:       up = 1'b0;
      2:       up = x && !s;
      default: up = x && s;
    endcase
    t = m + (up ? 1 : 0);
    if (t == (longint'(1) << W)) begin
      c = 1'b1;
      o = longint'(1) << (W - 1);
    end else begin
      c = 1'b0;
      o = t;
    end
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if (longint'(sig_o) != e_sig || carry_o != e_c || inexact_o != e_x) begin
      n_bad++;
      $display("FAIL %s: got sig=%h c=%0d x=%0d expected sig=%h c=%0d x=%0d",
               tag, sig_o, carry_o, inexact_o, e_sig[W-1:0], e_c, e_x);
    end
  endtask

  task automatic step(input bit s, input logic [W-1:0] m, input logic [2:0] g,
                      input logic [1:0] md, input bit e, input string tag);
    longint o;
    bit     c;
    bit     x;
    @(negedge clk);
    sign = s; sig = m; grs = g; mode = md; en = e;
    ref_round(s, longint'(m), int'(g), int'(md), o, c, x);
    @(posedge clk);
    if (e) begin
      e_sig = o; e_c = c; e_x = x;
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; sign = 1'b0; sig = '1; grs = 3'b111; mode = 2'd2;
    repeat (3) @(posedge clk);
    #2;
    compare("R10 in reset");
    @(negedge clk);
    rst_n = 1'b1; en = 1'b0;
    step(0, 24'h123456, 3'b111, 2'd2, 1'b0, "R10 after release");
    step(0, 24'h123456, 3'b111, 2'd2, 1'b0, "R10 after release");
    step(0, 24'h123456, 3'b111, 2'd2, 1'b0, "R10 after release");

    // R1 / R2 nearest-even: ties, below and above half
    step(0, 24'h000010, 3'b100, 2'd0, 1'b1, "R2 tie even");
    step(0, 24'h000011, 3'b100, 2'd0, 1'b1, "R2 tie odd");
    step(1, 24'h000011, 3'b100, 2'd0, 1'b1, "R2 tie odd neg");
    step(0, 24'h000010, 3'b011, 2'd0, 1'b1, "R2 below half");
    step(0, 24'h000010, 3'b101, 2'd0, 1'b1, "R2 above half sticky");
    step(0, 24'h000010, 3'b110, 2'd0, 1'b1, "R2 above half round");
    // R3 toward zero
    step(0, 24'h000011, 3'b111, 2'd1, 1'b1, "R3 pos");
    step(1, 24'h000011, 3'b111, 2'd1, 1'b1, "R3 neg");
    // R4 / R5 directed
    step(0, 24'h000010, 3'b001, 2'd2, 1'b1, "R4 pos sticky");
    step(1, 24'h000010, 3'b001, 2'd2, 1'b1, "R4 neg");
    step(1, 24'h000010, 3'b001, 2'd3, 1'b1, "R5 neg sticky");
    step(0, 24'h000010, 3'b100, 2'd3, 1'b1, "R5 pos");
    // R6 inexact in every mode
    for (int md = 0; md < 4; md++) begin
      step(1, 24'h0000F0, 3'b010, md[1:0], 1'b1, "R6 inexact");
      step(0, 24'h0000F0, 3'b000, md[1:0], 1'b1, "R6 exact");
    end
    // R7 exact passthrough, both signs, all-ones
    for (int md = 0; md < 4; md++) begin
      step(0, 24'hFFFFFF, 3'b000, md[1:0], 1'b1, "R7 exact ones pos");
      step(1, 24'hFFFFFF, 3'b000, md[1:0], 1'b1, "R7 exact ones neg");
    end
    // R8 wrap
    step(0, 24'hFFFFFF, 3'b110, 2'd0, 1'b1, "R8 wrap nearest");
    step(0, 24'hFFFFFF, 3'b001, 2'd2, 1'b1, "R8 wrap plus");
    step(1, 24'hFFFFFF, 3'b001, 2'd3, 1'b1, "R8 wrap minus");
    step(0, 24'hFFFFFF, 3'b100, 2'd1, 1'b1, "R8 no wrap toward zero");
    // R9 hold with enable low
    step(0, 24'h00ABCD, 3'b111, 2'd2, 1'b1, "R9 load");
    step(1, 24'h000000, 3'b000, 2'd0, 1'b0, "R9 hold");
    step(0, 24'hFFFFFF, 3'b111, 2'd2, 1'b0, "R9 hold");
    step(0, 24'hFFFFFF, 3'b111, 2'd2, 1'b1, "R9 reload");
    // Random mix: R1 R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] r;
      r = (i % 7 == 0) ? {W{1'b1}} : W'($urandom);
      step(1'($urandom), r, 3'($urandom), 2'($urandom), (i % 9) != 0, "R1 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule